// File: doc/BRIEF.md
# Selectable Output Divider With Auxiliary Clock Mux

This block sits behind a frequency synthesizer and turns its high-rate oscillator clock into two usable outputs. The primary output divides the oscillator clock by one of eight integer ratios between 2 and 10, chosen by a 3-bit select. The ratio code is not monotonic. For odd ratios a falling-edge helper flop stretches the waveform so that the duty cycle stays at 50%. The secondary output is taken from one of four sources: the reference clock, the reference divided by two, a constant low level, or the primary output divided by two.

A bypass input sends the reference clock straight to both outputs and skips the divider. An active-low power-down input clears all divider state, forces both outputs low and drops a shared drive-enable, which tells the pad drivers to go to high impedance. A new select code or a new secondary-source code is captured only when the current primary period ends, so a retune never cuts a pulse short.

The block has no data path, so it has no valid/ready interface. Every input is a plain control level, and the two clock outputs run without back-pressure.

Top module: `odiv_top`

## Requirements
- R1: The primary output period is N oscillator cycles, where the select code maps to N as follows: 3'b000→10, 3'b001→2, 3'b010→8, 3'b011→4, 3'b100→5, 3'b101→7, 3'b110→3, 3'b111→6.
- R2: For every ratio the primary output is high for exactly N oscillator half-cycles and low for exactly N half-cycles. For odd ratios this uses the falling edge.
- R3: The secondary source code selects the secondary output as follows: 2'b00 gives the reference clock, 2'b01 gives the reference divided by two (high for two reference half-periods, then low for two), 2'b10 gives a constant low, and 2'b11 gives the primary output divided by two (high for 2N oscillator half-cycles, then low for 2N).
- R4: While bypass is high and power-down is inactive, both outputs equal the reference clock, whatever the select and source codes are.
- R5: While power-down is low, the drive-enable is low and both clock outputs are low. While reset is low, both clock outputs are low and the drive-enable follows power-down.
- R6: A change of the select or source code during a primary period does not alter that period. The new code governs the periods that start after it ends.
- R7: When reset or power-down is released, the divider restarts from count zero: the primary output goes high at once, and the periods that follow have the correct length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | High-rate oscillator clock; drives the divider |
| ref_clk | input | 1 | Reference clock; source for bypass and for secondary codes 00 and 01 |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down; clears the dividers and silences the outputs |
| bypass_i | input | 1 | High routes the reference to both outputs |
| div_sel_i | input | 3 | Primary divide-ratio code (R1) |
| clk2_fn_i | input | 2 | Secondary output source code (R3) |
| clk1_o | output | 1 | Primary divided clock |
| clk2_o | output | 1 | Secondary clock |
| clk_oe_o | output | 1 | Pad drive-enable; low means both pads are high impedance |

## Verification
Every one of the eight select codes is swept with the halved-primary source active, and the high and low phases are counted on both outputs. This separates an error in the ratio table from a duty error that only shows on odd ratios, and it catches a halving stage that counts the wrong edge. A directed retune from ratio 10 to ratio 2, issued just after a rising edge, shows whether the code is staged at the period boundary or applied at once. Random pairs of codes mix ratio and source changes. Directed bypass, power-down and release sequences check the overrides and the restart from count zero.

// File: rtl/odiv_pkg.sv
`timescale 1ns/1ps
package odiv_pkg;
  localparam int SEL_W = 3;
  localparam int FN_W  = 2;
  localparam int CNT_W = 4;

  typedef enum logic [FN_W-1:0] {
    SRC_REF      = 2'b00,
    SRC_REF_HALF = 2'b01,
    SRC_OFF      = 2'b10,
    SRC_P_HALF   = 2'b11
  } aux_src_e;

  // Divide ratio for each select code; the ordering is part of the contract.
  function automatic logic [CNT_W-1:0] ratio_of(input logic [SEL_W-1:0] code);
    logic [CNT_W-1:0] r;
    case (code)
      3'b000:  r = CNT_W'(10);
      3'b001:  r = CNT_W'(2);
      3'b010:  r = CNT_W'(8);
      3'b011:  r = CNT_W'(4);
      3'b100:  r = CNT_W'(5);
      3'b101:  r = CNT_W'(7);
      3'b110:  r = CNT_W'(3);
      default: r = CNT_W'(6);
    endcase
    return r;
  endfunction

  // Cycles the rising-edge flop stays high: N/2 for even, (N+1)/2 for odd.
  function automatic logic [CNT_W-1:0] high_len(input logic [SEL_W-1:0] code);
    logic [CNT_W-1:0] r;
    r = ratio_of(code);
    return (r + CNT_W'(1)) >> 1;
  endfunction
endpackage

// File: rtl/odiv_core.sv
`timescale 1ns/1ps
module odiv_core import odiv_pkg::*; #(
  parameter bit HALF_EDGE = 1'b1
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             load_o,
  output logic             tc_o,
  output logic             clk_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, ratio_cur, hi_eff;
  logic [SEL_W-1:0] sel_q, sel_eff;
  logic             fresh_q, rise_q, fall_q, odd_cur;

  always_comb begin
    ratio_cur = ratio_of(sel_q);
    tc_o      = !fresh_q && (cnt_q == ratio_cur - CNT_W'(1));
    load_o    = fresh_q || tc_o;
    sel_eff   = load_o ? sel_i : sel_q;
    hi_eff    = high_len(sel_eff);
    cnt_d     = tc_o ? '0 : cnt_q + CNT_W'(1);
    odd_cur   = ratio_cur[0];
    clk_o     = odd_cur ? (rise_q & fall_q) : rise_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q   <= '0;
      sel_q   <= '0;
      fresh_q <= 1'b1;
      rise_q  <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      sel_q   <= sel_eff;
      fresh_q <= 1'b0;
      rise_q  <= (cnt_d < hi_eff);
    end
  end

  generate
    if (HALF_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge arst_n) begin
        if (!arst_n) fall_q <= 1'b1;
        else         fall_q <= rise_q;
      end
    end else begin : g_nofall
      assign fall_q = 1'b1;
    end
  endgenerate

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q < ratio_cur); // R1
  AST_PERIOD_OPENS_HIGH: assert property (@(posedge clk) disable iff (!arst_n)
    (cnt_q == '0) |-> rise_q); // R2
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!arst_n)
    !load_o |=> $stable(sel_q)); // R6
endmodule

// File: rtl/odiv_aux.sv
`timescale 1ns/1ps
module odiv_aux import odiv_pkg::*; (
  input  logic            vco_clk,
  input  logic            ref_clk,
  input  logic            arst_n,
  input  logic            load_i,
  input  logic            tc_i,
  input  logic [FN_W-1:0] fn_i,
  output logic            clk2_o
);
  aux_src_e fn_q;
  logic     p_half_q, r_half_q;

  always_ff @(posedge vco_clk or negedge arst_n) begin
    if (!arst_n) begin
      fn_q     <= SRC_REF;
      p_half_q <= 1'b0;
    end else begin
      if (load_i) fn_q <= aux_src_e'(fn_i);
      if (tc_i)   p_half_q <= ~p_half_q;
    end
  end

  always_ff @(posedge ref_clk or negedge arst_n) begin
    if (!arst_n) r_half_q <= 1'b0;
    else         r_half_q <= ~r_half_q;
  end

  always_comb begin
    case (fn_q)
      SRC_REF:      clk2_o = ref_clk;
      SRC_REF_HALF: clk2_o = r_half_q;
      SRC_OFF:      clk2_o = 1'b0;
      default:      clk2_o = p_half_q;
    endcase
  end

  AST_FN_HELD: assert property (@(posedge vco_clk) disable iff (!arst_n)
    !load_i |=> $stable(fn_q)); // R6
endmodule

// File: rtl/odiv_top.sv
`timescale 1ns/1ps
module odiv_top import odiv_pkg::*; #(
  parameter bit HALF_EDGE = 1'b1
) (
  input  logic             vco_clk,
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             bypass_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic [FN_W-1:0]  clk2_fn_i,
  output logic             clk1_o,
  output logic             clk2_o,
  output logic             clk_oe_o
);
  logic live_n, core_load, core_tc, core_clk, aux_clk;

  assign live_n = rst_n & pd_n;

  odiv_core #(.HALF_EDGE(HALF_EDGE)) u_core (
    .clk    (vco_clk),
    .arst_n (live_n),
    .sel_i  (div_sel_i),
    .load_o (core_load),
    .tc_o   (core_tc),
    .clk_o  (core_clk)
  );

  odiv_aux u_aux (
    .vco_clk (vco_clk),
    .ref_clk (ref_clk),
    .arst_n  (live_n),
    .load_i  (core_load),
    .tc_i    (core_tc),
    .fn_i    (clk2_fn_i),
    .clk2_o  (aux_clk)
  );

  always_comb begin
    clk_oe_o = pd_n;
    if (!live_n) begin
      clk1_o = 1'b0;
      clk2_o = 1'b0;
    end else if (bypass_i) begin
      clk1_o = ref_clk;
      clk2_o = ref_clk;
    end else begin
      clk1_o = core_clk;
      clk2_o = aux_clk;
    end
  end

  AST_PD_QUIET: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !pd_n |-> (!clk_oe_o && !clk1_o && !clk2_o)); // R5
  AST_BYPASS_REF: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (pd_n && bypass_i) |-> (clk1_o == ref_clk && clk2_o == ref_clk)); // R4
endmodule

// File: tb/odiv_top_test.sv
`timescale 1ns/1ps
module odiv_top_test;
  logic       vco_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd_n = 1'b1;
  logic       bypass = 1'b0;
  logic [2:0] sel = 3'b001;
  logic [1:0] fn = 2'b00;
  logic       clk1, clk2, oe;
  int         tests = 0;
  int         fails = 0;
  bit         done = 1'b0;

  odiv_top uut (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .pd_n(pd_n),
    .bypass_i(bypass), .div_sel_i(sel), .clk2_fn_i(fn),
    .clk1_o(clk1), .clk2_o(clk2), .clk_oe_o(oe)
  );

  always #2.5 vco_clk = ~vco_clk;
  always #7.3 ref_clk = ~ref_clk;

  function automatic int exp_ratio(input logic [2:0] s);
    case (s)
      3'b000: return 10;
      3'b001: return 2;
      3'b010: return 8;
      3'b011: return 4;
      3'b100: return 5;
      3'b101: return 7;
      3'b110: return 3;
      default: return 6;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit on_ref);
    if (on_ref) begin @(ref_clk); #1; end
    else begin @(vco_clk); #1; end
  endtask

  task automatic halves(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  function automatic logic pick(input bit w);
    return w ? clk2 : clk1;
  endfunction

  task automatic measure(input bit w, input bit on_ref, output int hi, output int lo);
    int guard;
    guard = 0; hi = 0; lo = 0;
    step(on_ref);
    while (pick(w) != 1'b0 && guard < 200) begin step(on_ref); guard++; end
    while (pick(w) != 1'b1 && guard < 400) begin step(on_ref); guard++; end
    while (pick(w) == 1'b1 && guard < 600) begin hi++; step(on_ref); guard++; end
    while (pick(w) == 1'b0 && guard < 800) begin lo++; step(on_ref); guard++; end
  endtask

  task automatic check_clk2(input logic [1:0] f, input logic [2:0] s);
    int hi, lo, bad;
    case (f)
      2'b00: begin
        bad = 0;
        for (int i = 0; i < 12; i++) begin step(1'b1); if (clk2 != ref_clk) bad++; end
        check("R3 src 00 follows reference", bad, 0);
      end
      2'b01: begin
        measure(1'b1, 1'b1, hi, lo);
        check("R3 src 01 high ref halves", hi, 2);
        check("R3 src 01 low ref halves", lo, 2);
      end
      2'b10: begin
        bad = 0;
        for (int i = 0; i < 40; i++) begin step(1'b0); if (clk2) bad++; end
        check("R3 src 10 stays low", bad, 0);
      end
      default: begin
        measure(1'b1, 1'b0, hi, lo);
        check("R3 src 11 high halves", hi, 2 * exp_ratio(s));
        check("R3 src 11 low halves", lo, 2 * exp_ratio(s));
      end
    endcase
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #500000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int hi, lo, bad, guard;
    void'($urandom(32'd7301));

    // Reset state
    halves(6);
    check("R5 reset clk1 low", int'(clk1), 0);
    check("R5 reset clk2 low", int'(clk2), 0);
    check("R5 reset oe follows pd", int'(oe), 1);
    rst_n = 1'b1;
    #0.5;
    check("R7 clk1 high right after reset release", int'(clk1), 1);

    // Sweep of every ratio with the halved primary on the secondary output
    fn = 2'b11;
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      halves(50);
      measure(1'b0, 1'b0, hi, lo);
      check($sformatf("R1 R2 sel %0d high halves", s), hi, exp_ratio(3'(s)));
      check($sformatf("R1 R2 sel %0d low halves", s), lo, exp_ratio(3'(s)));
      check_clk2(2'b11, 3'(s));
    end

    // Remaining secondary sources
    sel = 3'b011;
    for (int f = 0; f < 3; f++) begin
      fn = 2'(f);
      halves(50);
      check_clk2(2'(f), sel);
    end

    // Retune issued mid-period takes effect at the period boundary
    fn = 2'b10;
    sel = 3'b000;
    halves(60);
    guard = 0;
    while (clk1 != 1'b0 && guard < 100) begin step(1'b0); guard++; end
    while (clk1 != 1'b1 && guard < 200) begin step(1'b0); guard++; end
    sel = 3'b001;
    hi = 0; lo = 0;
    while (clk1 == 1'b1 && guard < 300) begin hi++; step(1'b0); guard++; end
    while (clk1 == 1'b0 && guard < 400) begin lo++; step(1'b0); guard++; end
    check("R6 current period keeps old high", hi, 10);
    check("R6 current period keeps old low", lo, 10);
    measure(1'b0, 1'b0, hi, lo);
    check("R6 next period uses new high", hi, 2);
    check("R6 next period uses new low", lo, 2);

    // Bypass overrides everything
    bypass = 1'b1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      step(1'b1);
      if (clk1 != ref_clk || clk2 != ref_clk) bad++;
    end
    check("R4 bypass both outputs follow reference", bad, 0);
    bypass = 1'b0;

    // Power-down and release
    sel = 3'b101;
    halves(40);
    pd_n = 1'b0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      step(1'b0);
      if (clk1 || clk2 || oe) bad++;
    end
    check("R5 power-down silences outputs", bad, 0);
    check("R5 power-down drops enable", int'(oe), 0);
    bypass = 1'b1;
    step(1'b1);
    check("R5 power-down beats bypass", int'(clk1 | clk2), 0);
    bypass = 1'b0;
    step(1'b0);
    pd_n = 1'b1;
    #0.5;
    check("R7 clk1 high right after power-down release", int'(clk1), 1);
    check("R5 enable back after release", int'(oe), 1);
    measure(1'b0, 1'b0, hi, lo);
    check("R7 first full period after release high", hi, 7);
    check("R7 first full period after release low", lo, 7);

    // Random code pairs
    for (int it = 0; it < 12; it++) begin
      logic [2:0] rs;
      logic [1:0] rf;
      rs = 3'($urandom % 8);
      rf = 2'($urandom % 4);
      sel = rs;
      fn = rf;
      halves(50);
      measure(1'b0, 1'b0, hi, lo);
      check($sformatf("R1 R2 random sel %0d high", rs), hi, exp_ratio(rs));
      check($sformatf("R1 R2 random sel %0d low", rs), lo, exp_ratio(rs));
      check_clk2(rf, rs);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule